// File: doc/BRIEF.md
# Core Step Sequencer with Timed Clear

This block is a synchronous controller that supervises a self-timed processing core. When the external active-low reset is seen, it holds a clear line toward the core for a fixed, parameterised number of clock cycles. At the default setting this is 1,000,000 cycles, which is 20 ms at a 50 MHz clock. After the clear, it advances the core one instruction at a time over a four-phase request/acknowledge handshake. It repeats that handshake for as long as reset stays released.

The acknowledge from the core is asynchronous to the clock. It passes through a two-flop synchronizer before the state machine uses it. The reset input has its own synchronizer: assertion acts at once, and release is seen two clock edges later. A reset at any point aborts the handshake and restarts the full clear.

The state machine has five states, held on the `seq_state` output with these codes: RESET_WAIT=0, CLEAR=1, REQ_HIGH=2, WAIT_ACK_LOW=3, IDLE_GAP=4.

The transitions are:
- **RESET_WAIT→CLEAR**: on the first edge at which the synchronized reset reads released.
- **CLEAR→REQ_HIGH**: once the clear timer has counted `CLEAR_CYCLES` cycles.
- **REQ_HIGH→WAIT_ACK_LOW**: when the synchronized acknowledge reads high.
- **WAIT_ACK_LOW→IDLE_GAP**: when the synchronized acknowledge reads low.
- **IDLE_GAP→REQ_HIGH**: always, after one cycle.
- **Any state→RESET_WAIT**: when reset is asserted.

Top module: `core_step_sequencer`

## Requirements
- R1: While `rst_n_ext` is low, the block shows state RESET_WAIT (code 0) with `core_clear`=1 and `core_req`=0. This takes effect immediately on assertion, without waiting for a clock edge.
- R2: After `rst_n_ext` rises, the state enters CLEAR (code 1) on the third rising clock edge. It stays in CLEAR for exactly `CLEAR_CYCLES` cycles, with `core_clear` high throughout.
- R3: On the edge that ends CLEAR, `core_clear` falls and `core_req` rises together, in state REQ_HIGH (code 2).
- R4: `core_clear` and `core_req` are never high at the same time.
- R5: In REQ_HIGH, `core_req` falls and the state becomes WAIT_ACK_LOW (code 3) on the third rising edge after `core_ack` rises. The request is held for any acknowledge delay.
- R6: In WAIT_ACK_LOW, the state becomes IDLE_GAP (code 4) on the third rising edge after `core_ack` falls. `core_req` rises again on the fourth, so at least one idle cycle separates requests.
- R7: `core_ack` activity during RESET_WAIT or CLEAR has no effect on the clear length or on the first request.
- R8: Asserting `rst_n_ext` during a handshake drops `core_req` at once. After release, the full clear sequence of R2 runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (50 MHz in the target) |
| rst_n_ext | input | 1 | External reset, active low, asynchronous |
| core_ack | input | 1 | Acknowledge from the core, asynchronous |
| core_clear | output | 1 | Clear toward the core, active high |
| core_req | output | 1 | Step request toward the core |
| seq_state | output | 3 | Current state code |

## Verification
On every cycle, the bound checker enforces the following:
- clear and request are never high together;
- a request rises only out of CLEAR or IDLE_GAP;
- clear falls only into a request;
- a request falls only after the synchronized acknowledge was high;
- each completed clear lasted exactly `CLEAR_CYCLES` cycles.

Only the bench scenarios can show the exact latency through both synchronizers for each acknowledge delay. They also show that acknowledge pulses during the clear are ignored, and that a reset in the middle of a handshake restarts the whole sequence.

// File: rtl/core_step_pkg.sv
package core_step_pkg;
    typedef enum logic [2:0] {
        ST_RESET_WAIT   = 3'd0,
        ST_CLEAR        = 3'd1,
        ST_REQ_HIGH     = 3'd2,
        ST_WAIT_ACK_LOW = 3'd3,
        ST_IDLE_GAP     = 3'd4
    } seq_state_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int  STAGES    = 2,
    parameter bit  RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[i] <= RESET_VAL;
                end else if (i == 0) begin
                    chain[i] <= d;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clear_timer.sv
module clear_timer #(
    parameter int CLEAR_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CLEAR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CLEAR_CYCLES - 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (!run) begin
            count <= '0;
        end else if (count != LAST) begin
            count <= count + 1'b1;
        end
    end

    assign done = run && (count == LAST);
endmodule

// File: rtl/core_step_sequencer.sv
module core_step_sequencer
    import core_step_pkg::*;
#(
    parameter int CLEAR_CYCLES = 1_000_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n_ext,
    input  logic       core_ack,
    output logic       core_clear,
    output logic       core_req,
    output logic [2:0] seq_state
);
    seq_state_t state_q, state_d;
    logic       rst_sync_n;
    logic       ack_sync;
    logic       clear_done;

    sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_rst_sync (
        .clk   (clk),
        .rst_n (rst_n_ext),
        .d     (1'b1),
        .q     (rst_sync_n)
    );

    sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .d     (core_ack),
        .q     (ack_sync)
    );

    clear_timer #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .run   (state_q == ST_CLEAR),
        .done  (clear_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) begin
            state_q <= ST_RESET_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET_WAIT:   state_d = ST_CLEAR;
            ST_CLEAR:        if (clear_done) state_d = ST_REQ_HIGH;
            ST_REQ_HIGH:     if (ack_sync)   state_d = ST_WAIT_ACK_LOW;
            ST_WAIT_ACK_LOW: if (!ack_sync)  state_d = ST_IDLE_GAP;
            ST_IDLE_GAP:     state_d = ST_REQ_HIGH;
            default:         state_d = ST_RESET_WAIT;
        endcase
    end

    // Moore outputs
    always_comb begin
        core_clear = 1'b0;
        core_req   = 1'b0;
        unique case (state_q)
            ST_RESET_WAIT,
            ST_CLEAR:        core_clear = 1'b1;
            ST_REQ_HIGH:     core_req   = 1'b1;
            ST_WAIT_ACK_LOW,
            ST_IDLE_GAP:     ;
            default:         core_clear = 1'b1;
        endcase
    end

    assign seq_state = state_q;
endmodule

// File: rtl/core_step_checker.sv
module core_step_checker
    import core_step_pkg::*;
#(
    parameter int CLEAR_CYCLES = 1_000_000
) (
    input logic       clk,
    input logic       rst_n_ext,
    input logic       core_clear,
    input logic       core_req,
    input logic [2:0] seq_state,
    input logic       ack_sync
);
    logic [31:0] clr_cnt;

    always_ff @(posedge clk or negedge rst_n_ext) begin
        if (!rst_n_ext) begin
            clr_cnt <= '0;
        end else if (seq_state == ST_CLEAR) begin
            clr_cnt <= clr_cnt + 1;
        end else begin
            clr_cnt <= '0;
        end
    end

    assert_reset_outputs_R1: assert property (@(posedge clk)
        !rst_n_ext |-> (core_clear && !core_req));

    assert_clear_length_R2: assert property (@(posedge clk) disable iff (!rst_n_ext)
        (seq_state == ST_REQ_HIGH && $past(seq_state) == ST_CLEAR)
            |-> ($past(clr_cnt) == 32'(CLEAR_CYCLES - 1)));

    assert_clear_into_req_R3: assert property (@(posedge clk) disable iff (!rst_n_ext)
        $fell(core_clear) |-> core_req);

    assert_no_overlap_R4: assert property (@(posedge clk)
        !(core_clear && core_req));

    assert_req_drop_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n_ext)
        $fell(core_req) |-> $past(ack_sync));

    assert_req_rise_source_R6: assert property (@(posedge clk) disable iff (!rst_n_ext)
        $rose(core_req) |->
            ($past(seq_state) == ST_IDLE_GAP || $past(seq_state) == ST_CLEAR));
endmodule

bind core_step_sequencer core_step_checker #(.CLEAR_CYCLES(CLEAR_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n_ext  (rst_n_ext),
    .core_clear (core_clear),
    .core_req   (core_req),
    .seq_state  (seq_state),
    .ack_sync   (ack_sync)
);

// File: tb/core_step_sequencer_tb.sv
module core_step_sequencer_tb;
    localparam int N = 8;

    logic       clk = 1'b0;
    logic       rst_n_ext = 1'b0;
    logic       core_ack = 1'b0;
    logic       core_clear;
    logic       core_req;
    logic [2:0] seq_state;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    core_step_sequencer #(.CLEAR_CYCLES(N)) u_dut (
        .clk        (clk),
        .rst_n_ext  (rst_n_ext),
        .core_ack   (core_ack),
        .core_clear (core_clear),
        .core_req   (core_req),
        .seq_state  (seq_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all(input string tag, input int st, input int clr, input int req);
        chk({tag, " state"}, int'(seq_state), st);
        chk({tag, " clear"}, int'(core_clear), clr);
        chk({tag, " req"},   int'(core_req), req);
    endtask

    // R1, R2, R3, R7, R8: assert reset, release, walk the whole clear
    task automatic run_reset(input bit pulse_ack);
        @(negedge clk);
        rst_n_ext = 1'b0;
        #1;
        chk_all("R1/R8 reset asserted", 0, 1, 0);
        core_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk_all("R1 reset held", 0, 1, 0);
        rst_n_ext = 1'b1;
        for (int k = 1; k <= 3 + N; k++) begin
            @(negedge clk);
            if (k < 3)      chk_all("R2 sync release", 0, 1, 0);
            else if (k < 3 + N) chk_all(pulse_ack ? "R7 clear with ack" : "R2 clear", 1, 1, 0);
            else            chk_all("R3 first request", 2, 0, 1);
            if (pulse_ack && k == 5) core_ack = 1'b1;
            if (pulse_ack && k == 7) core_ack = 1'b0;
        end
    endtask

    // R5, R6: one handshake, entered at a negedge with req high
    task automatic handshake(input int rd, input int fd);
        for (int i = 0; i < rd; i++) begin
            @(negedge clk);
            chk_all("R5 waiting ack", 2, 0, 1);
        end
        core_ack = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            if (k < 3) chk_all("R5 ack syncing", 2, 0, 1);
            else       chk_all("R5 req dropped", 3, 0, 0);
        end
        for (int i = 0; i < fd; i++) begin
            @(negedge clk);
            chk_all("R6 ack held", 3, 0, 0);
        end
        core_ack = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k < 3)       chk_all("R6 ack fall syncing", 3, 0, 0);
            else if (k == 3) chk_all("R6 idle gap", 4, 0, 0);
            else             chk_all("R6 next request", 2, 0, 1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1;
        chk_all("R1 initial reset", 0, 1, 0);
        run_reset(1'b0);
        for (int rd = 0; rd < 4; rd++)
            for (int fd = 0; fd < 4; fd++)
                handshake(rd, fd);
        run_reset(1'b1);
        handshake(1, 2);
        // R8: reset in the middle of a handshake (ack high, WAIT_ACK_LOW)
        core_ack = 1'b1;
        repeat (3) @(negedge clk);
        chk_all("R8 pre-abort", 3, 0, 0);
        run_reset(1'b0);
        // R8: reset while req is high
        run_reset(1'b0);
        handshake(2, 0);
        handshake(0, 3);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule